// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a 32-bit processor core. The registers are arranged as a ring of overlapping windows. A current window pointer (CWP) chooses which window the three register ports see. Each port takes a 5-bit architectural register number. The block translates that number, using the CWP, into an index of one flat physical array. The array holds 8 shared globals plus 16 registers for each window.

A save pulse moves the pointer down by one window, wrapping around the ring. A restore pulse moves it up by one window. A caller's outgoing registers therefore become the incoming registers of the window that save moves into. A window-invalid mask marks windows that must not be entered. A move into a marked window is refused, and the block raises a one-cycle overflow flag for a refused save or an underflow flag for a refused restore. The surrounding core handles those flags.

Top module: `win_regfile`

## Requirements
- R1: After reset the CWP is 0, every register reads 0, and both flags are low.
- R2: Architectural register 0 always reads as zero, and a write to it changes nothing.
- R3: Registers 1 to 7 (globals) are the same physical registers in every window.
- R4: Registers 8 to 15 (outs) of window w are the same physical registers as registers 24 to 31 (ins) of window (w-1) mod NWIN.
- R5: Registers 16 to 23 (locals) are private to each window. A write to a local in one window is not visible in any other window.
- R6: A save pulse that is accepted sets the CWP to (CWP-1) mod NWIN at the clock edge. A restore pulse that is accepted sets it to (CWP+1) mod NWIN.
- R7: If mask bit (CWP-1) mod NWIN is set, a save pulse leaves the CWP unchanged and drives the overflow flag high for the one cycle after that edge.
- R8: If mask bit (CWP+1) mod NWIN is set, a restore pulse leaves the CWP unchanged and drives the underflow flag high for the one cycle after that edge.
- R9: Reads are combinational. A write commits at the clock edge, in the window given by the CWP before any move at that edge. A read of the register being written in the same cycle returns the old value.
- R10: If save and restore are high in the same cycle, the CWP does not move and neither flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_addr_a | input | 5 | Architectural number for read port A |
| rd_data_a | output | XLEN | Read port A data |
| rd_addr_b | input | 5 | Architectural number for read port B |
| rd_data_b | output | XLEN | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Architectural number to write |
| wr_data | input | XLEN | Write data |
| save_i | input | 1 | Move the window pointer down |
| restore_i | input | 1 | Move the window pointer up |
| win_mask | input | NWIN | One bit per window; a set bit protects that window |
| cwp_o | output | CW | Current window pointer |
| ovf_o | output | 1 | Refused save, one cycle |
| unf_o | output | 1 | Refused restore, one cycle |

## Verification
The hardest cases to reach from the ports are the ones where two windows share storage. A value written in one window has to be looked for under a different register number after the pointer has moved. That includes a move across the wrap from window 0 to window NWIN-1. The stimulus writes a distinct value into an out register, issues a save across the wrap, and then reads the matching in register. It also writes a local in one window, moves away, and confirms that the register reads differently in the other window. A full loop of saves then checks that the pointer returns to its start.

// File: rtl/win_regfile.sv
module win_regfile #(
  parameter int NWIN = 8,
  parameter int XLEN = 32,
  localparam int NPHYS = 8 + 16 * NWIN,
  localparam int PW = $clog2(NPHYS),
  localparam int CW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4:0]      rd_addr_a,
  output logic [XLEN-1:0] rd_data_a,
  input  logic [4:0]      rd_addr_b,
  output logic [XLEN-1:0] rd_data_b,
  input  logic            wr_en,
  input  logic [4:0]      wr_addr,
  input  logic [XLEN-1:0] wr_data,
  input  logic            save_i,
  input  logic            restore_i,
  input  logic [NWIN-1:0] win_mask,
  output logic [CW-1:0]   cwp_o,
  output logic            ovf_o,
  output logic            unf_o
);

  logic [XLEN-1:0] regs [NPHYS];
  logic [CW-1:0] cwp, cwp_dn, cwp_up;

  function automatic logic [PW-1:0] phys(input logic [4:0] r, input logic [CW-1:0] w);
    int base, nbase;
    base  = 8 + 16 * int'(w);
    nbase = 8 + 16 * ((int'(w) == NWIN - 1) ? 0 : int'(w) + 1);
    case (r[4:3])
      2'd0:    return PW'(int'(r[2:0]));
      2'd1:    return PW'(base + int'(r[2:0]));
      2'd2:    return PW'(base + 8 + int'(r[2:0]));
      default: return PW'(nbase + int'(r[2:0]));
    endcase
  endfunction

  assign cwp_dn = (cwp == '0) ? CW'(NWIN - 1) : cwp - 1'b1;
  assign cwp_up = (int'(cwp) == NWIN - 1) ? '0 : cwp + 1'b1;
  assign cwp_o  = cwp;

  assign rd_data_a = (rd_addr_a == 5'd0) ? '0 : regs[phys(rd_addr_a, cwp)];
  assign rd_data_b = (rd_addr_b == 5'd0) ? '0 : regs[phys(rd_addr_b, cwp)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) regs[i] <= '0;
    end else if (wr_en && wr_addr != 5'd0) begin
      regs[phys(wr_addr, cwp)] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cwp   <= '0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else begin
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
      if (save_i && !restore_i) begin
        if (win_mask[cwp_dn]) ovf_o <= 1'b1;
        else                  cwp   <= cwp_dn;
      end else if (restore_i && !save_i) begin
        if (win_mask[cwp_up]) unf_o <= 1'b1;
        else                  cwp   <= cwp_up;
      end
    end
  end

  assert_zero_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_a == 5'd0) |-> (rd_data_a == '0));

  assert_cwp_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cwp_o) < NWIN);

  assert_save_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (save_i && !restore_i && !ovf_o && !unf_o && $past(rst_n) && !$past(save_i) && !$past(restore_i)) |=>
      (ovf_o || cwp_o == (($past(cwp_o) == '0) ? CW'(NWIN - 1) : $past(cwp_o) - 1'b1)));

  assert_ovf_holds_cwp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> $stable(cwp_o));

  assert_unf_holds_cwp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unf_o) |-> $stable(cwp_o));

  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf_o, unf_o}));

  assert_both_no_move_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (save_i && restore_i) |=> ($stable(cwp_o) && !ovf_o && !unf_o));

endmodule

// File: tb/win_regfile_tb_top.sv
module win_regfile_tb_top;
  localparam int NWIN = 8;
  localparam int CW = 3;

  logic clk = 0, rst_n = 0;
  logic [4:0] ra = 0, rb = 0, wa = 0;
  logic [31:0] rda, rdb, wd = 0;
  logic we = 0, sv = 0, rs = 0;
  logic [NWIN-1:0] mask = 0;
  logic [CW-1:0] cwp;
  logic ovf, unf;

  always #10 clk = ~clk;

  win_regfile #(.NWIN(NWIN), .XLEN(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .rd_addr_a(ra), .rd_data_a(rda), .rd_addr_b(rb), .rd_data_b(rdb),
    .wr_en(we), .wr_addr(wa), .wr_data(wd), .save_i(sv), .restore_i(rs), .win_mask(mask),
    .cwp_o(cwp), .ovf_o(ovf), .unf_o(unf));

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  event mon_ev;
  int checks = 0, errors = 0;
  bit done = 0;

  always @(mon_ev) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = rda;
        1: act = rdb;
        2: act = 32'(cwp);
        3: act = 32'(ovf);
        default: act = 32'(unf);
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_v(int kind, logic [31:0] exp, string tag);
    q.push_back('{kind, exp, tag});
    ->mon_ev;
    #1;
  endtask

  task automatic rd(logic [4:0] r, logic [31:0] exp, string tag);
    ra = r; rb = r; #1;
    expect_v(0, exp, tag);
    expect_v(1, exp, tag);
  endtask

  task automatic wr(logic [4:0] r, logic [31:0] d);
    @(negedge clk); we = 1; wa = r; wd = d;
    @(negedge clk); we = 0;
  endtask

  task automatic mv(bit s, bit r);
    @(negedge clk); sv = s; rs = r;
    @(negedge clk); sv = 0; rs = 0; #1;
  endtask

  task automatic flags(bit o, bit u, string tag);
    expect_v(3, 32'(o), tag);
    expect_v(4, 32'(u), tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    expect_v(2, 0, "R1 cwp reset");
    flags(0, 0, "R1 flags reset");
    rd(5'd5, 0, "R1 global reset");
    rd(5'd20, 0, "R1 local reset");

    wr(5'd0, 32'hDEAD_BEEF);
    rd(5'd0, 0, "R2 r0 zero");

    wr(5'd3, 32'h1111_0003);
    wr(5'd8, 32'hAAAA_0008);
    wr(5'd16, 32'h4C4C_0000);
    mv(1, 0);
    expect_v(2, 7, "R6 save wraps 0 to 7");
    flags(0, 0, "R6 no flag on accepted save");
    rd(5'd3, 32'h1111_0003, "R3 global shared");
    rd(5'd24, 32'hAAAA_0008, "R4 outs become ins across wrap");
    rd(5'd16, 0, "R5 local private in window 7");
    wr(5'd16, 32'h4C4C_0007);
    wr(5'd15, 32'hBBBB_000F);
    mv(1, 0);
    expect_v(2, 6, "R6 save 7 to 6");
    rd(5'd31, 32'hBBBB_000F, "R4 r15 of 7 is r31 of 6");
    mv(0, 1);
    mv(0, 1);
    expect_v(2, 0, "R6 restore wraps 7 to 0");
    rd(5'd16, 32'h4C4C_0000, "R5 local of window 0 kept");
    rd(5'd8, 32'hAAAA_0008, "R4 out still in window 0");

    mask = 8'h80;
    mv(1, 0);
    flags(1, 0, "R7 overflow pulse");
    expect_v(2, 0, "R7 cwp held on overflow");
    @(negedge clk); #1;
    flags(0, 0, "R7 overflow one cycle");
    mask = 8'h02;
    mv(0, 1);
    flags(0, 1, "R8 underflow pulse");
    expect_v(2, 0, "R8 cwp held on underflow");
    @(negedge clk); #1;
    flags(0, 0, "R8 underflow one cycle");
    mask = 0;

    mv(1, 1);
    expect_v(2, 0, "R10 both pulses no move");
    flags(0, 0, "R10 both pulses no flag");

    wr(5'd9, 32'h0000_0009);
    @(negedge clk); we = 1; wa = 5'd9; wd = 32'h9999_9999; ra = 5'd9; rb = 5'd9; #1;
    expect_v(0, 32'h0000_0009, "R9 old value during write");
    @(negedge clk); we = 0; #1;
    expect_v(0, 32'h9999_9999, "R9 new value after edge");

    @(negedge clk); we = 1; wa = 5'd17; wd = 32'h1700_0000; sv = 1;
    @(negedge clk); we = 0; sv = 0; #1;
    expect_v(2, 7, "R9 cwp moved with write");
    rd(5'd17, 0, "R9 write landed in old window");
    mv(0, 1);
    rd(5'd17, 32'h1700_0000, "R9 write in window 0");

    for (int i = 1; i <= NWIN; i++) begin
      mv(1, 0);
      expect_v(2, 32'((NWIN - i) % NWIN), "R6 save loop");
    end
    rd(5'd3, 32'h1111_0003, "R3 global after full loop");

    #5;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule